// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects a parameterized set of level-sensitive interrupt lines (41 by default) and turns them into one request toward a processor core, together with the number of the line that should be serviced. Each line has its own enable bit, pending bit and priority level. Software reaches them through a word-addressed write/read port. Enables and pending bits are changed only through separate set and clear words, which write ones, so no read-modify-write sequence is ever needed.

Arbitration uses only the implemented upper priority bits (three by default). A smaller level is more urgent. A threshold register filters out levels that are too low in urgency. A grouping field divides the implemented bits into a preemption group and a sub-priority.

The controller keeps a stack of the levels currently in service. An acknowledge strobe from the core claims the current winner and pushes its level. An end-of-service strobe pops the stack. A new request interrupts a running handler only when its group is strictly more urgent than the group of that handler. A master gate can hold back the request output without touching any per-line enable.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset, every enable bit, pending bit, priority level and the threshold are zero. The grouping field and the master gate are zero, the service stack is empty, and `irq_o` is low.
- R2: The register map uses word addresses:
  - 0x00 is control: bit 0 is the master gate and bits 10:8 are grouping.
  - 0x01 is the threshold, held in bits 7:5.
  - 0x08+w sets enables and 0x0C+w clears enables, where w is the 32-line word.
  - 0x10+w sets pending bits and 0x14+w clears them.
  - 0x40+n is the priority of line n.
  - Writing a one to a set word sets the matching bit, and writing a one to a clear word clears it. Both addresses of a pair read back the current bits.
- R3: Software can set a pending bit whether or not its line is enabled. Clearing a pending bit discards a request that has not been serviced yet, and a line that is pending but disabled never wins.
- R4: A priority word stores only bits 7:5, and bits 4:0 read back as zero. The control word reads back only bit 0 and bits 10:8.
- R5: Only lines that are both enabled and pending take part. The smallest level wins, and on equal levels the lowest line number wins. `irq_id_o` gives the winner's number.
- R6: When the threshold level T is non-zero, any line whose level is T or larger is blocked. A threshold of 0 blocks nothing.
- R7: While the master gate is 0, `irq_o` stays low. The per-line enables are unchanged and still read back.
- R8: The grouping encoding g gives min(3, 7-g) preemption bits, taken from the top of the level. Encodings 0 through 4 therefore behave alike. While a handler is in service, `irq_o` rises only when the winner's group is strictly smaller than the group of the top of the stack; sub-priority alone never preempts.
- R9: `ack_i`, while `irq_o` is high, clears the winner's pending bit and pushes its level onto the service stack. `eos_i` pops the stack. A request pended during a more urgent handler waits until that handler has been popped.
- R10: A line held high sets its pending bit on every clock, so clearing that bit while the line is still asserted leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines_i | input | N_LINES | Level-sensitive interrupt lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| ack_i | input | 1 | Core claims the current winner |
| eos_i | input | 1 | Core finished the innermost handler |
| irq_o | output | 1 | Interrupt request to the core |
| irq_id_o | output | ID_W | Number of the winning line |

## Verification
On every cycle, the assertions check four things: a raised request always names a line that is enabled and pending; that line's level lies below a non-zero threshold and below the level at the top of the service stack; a closed gate keeps the request low; and the stack depth moves by exactly one on an acknowledge or end-of-service and never exceeds its bound. Some behaviours can only be shown by the bench's scenarios:
- tie-breaking by line number;
- the grouping boundary, where encoding 4 preempts and encoding 5 does not;
- a request pended from inside a handler waiting until the pop;
- a pending bit cleared while its line is still asserted, which stays set;
- masking of unimplemented register bits.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int unsigned REG_AW = 8;
    localparam int unsigned REG_DW = 32;

    // Word addresses
    localparam logic [7:0] A_CTRL   = 8'h00;
    localparam logic [7:0] A_THRESH = 8'h01;
    localparam logic [7:0] A_EN_SET = 8'h08;
    localparam logic [7:0] A_EN_CLR = 8'h0C;
    localparam logic [7:0] A_PD_SET = 8'h10;
    localparam logic [7:0] A_PD_CLR = 8'h14;
    localparam logic [7:0] A_PRIO   = 8'h40;

    // Arbitration result carried from the arbiter to the top
    typedef struct packed {
        logic       valid;
        logic [7:0] id;
        logic [7:0] lvl;
    } win_t;

    // Number of implemented level bits that form the preemption group
    function automatic int unsigned preempt_bits(input logic [2:0] grp,
                                                 input int unsigned impl);
        int unsigned avail;
        avail = 32'd7 - 32'(grp);
        return (avail < impl) ? avail : impl;
    endfunction

    // Level with its sub-priority bits removed
    function automatic logic [7:0] group_key(input logic [7:0] lvl,
                                             input int unsigned gb,
                                             input int unsigned impl);
        logic [7:0] keep;
        keep = 8'hFF << (impl - gb);
        return lvl & keep;
    endfunction

endpackage

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int unsigned N = 41,
    parameter int unsigned P = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N-1:0]            lines_i,
    input  logic                    we_i,
    input  logic [REG_AW-1:0]       addr_i,
    input  logic [REG_DW-1:0]       wdata_i,
    output logic [REG_DW-1:0]       rdata_o,
    input  logic                    ack_clr_i,
    input  logic [7:0]              ack_id_i,
    output logic [N-1:0]            en_o,
    output logic [N-1:0]            pend_o,
    output logic [N-1:0][P-1:0]     prio_o,
    output logic [2:0]              grp_o,
    output logic [P-1:0]            thresh_o,
    output logic                    master_o
);

    localparam int unsigned NW = (N + 31) / 32;
    localparam int unsigned XW = NW * 32;

    logic [N-1:0]        en_q, pend_q, en_d, pend_d, ack_mask;
    logic [N-1:0][P-1:0] prio_q;
    logic [2:0]          grp_q;
    logic [P-1:0]        thresh_q;
    logic                master_q;
    logic [XW-1:0]       en_s, en_c, pd_s, pd_c, en_x, pd_x;

    // Write decode for the set/clear words
    always_comb begin
        en_s = '0;
        en_c = '0;
        pd_s = '0;
        pd_c = '0;
        for (int w = 0; w < NW; w++) begin
            if (we_i && addr_i == 8'(A_EN_SET + w)) en_s[w*32 +: 32] = wdata_i;
            if (we_i && addr_i == 8'(A_EN_CLR + w)) en_c[w*32 +: 32] = wdata_i;
            if (we_i && addr_i == 8'(A_PD_SET + w)) pd_s[w*32 +: 32] = wdata_i;
            if (we_i && addr_i == 8'(A_PD_CLR + w)) pd_c[w*32 +: 32] = wdata_i;
        end
        for (int i = 0; i < N; i++) begin
            ack_mask[i] = ack_clr_i && (ack_id_i == 8'(i));
        end
        en_d   = (en_q | en_s[N-1:0]) & ~en_c[N-1:0];
        // an asserted line wins over any clear in the same cycle
        pend_d = (pend_q & ~pd_c[N-1:0] & ~ack_mask) | pd_s[N-1:0] | lines_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            pend_q   <= '0;
            prio_q   <= '0;
            grp_q    <= '0;
            thresh_q <= '0;
            master_q <= 1'b0;
        end else begin
            en_q   <= en_d;
            pend_q <= pend_d;
            if (we_i && addr_i == A_CTRL) begin
                master_q <= wdata_i[0];
                grp_q    <= wdata_i[10:8];
            end
            if (we_i && addr_i == A_THRESH) thresh_q <= wdata_i[7 -: P];
            for (int n = 0; n < N; n++) begin
                if (we_i && addr_i == 8'(A_PRIO + n)) prio_q[n] <= wdata_i[7 -: P];
            end
        end
    end

    // Read mux
    always_comb begin
        en_x = '0;
        pd_x = '0;
        en_x[N-1:0] = en_q;
        pd_x[N-1:0] = pend_q;
        rdata_o = '0;
        if (addr_i == A_CTRL) begin
            rdata_o[0]    = master_q;
            rdata_o[10:8] = grp_q;
        end
        if (addr_i == A_THRESH) rdata_o[7 -: P] = thresh_q;
        for (int w = 0; w < NW; w++) begin
            if (addr_i == 8'(A_EN_SET + w) || addr_i == 8'(A_EN_CLR + w))
                rdata_o = en_x[w*32 +: 32];
            if (addr_i == 8'(A_PD_SET + w) || addr_i == 8'(A_PD_CLR + w))
                rdata_o = pd_x[w*32 +: 32];
        end
        for (int n = 0; n < N; n++) begin
            if (addr_i == 8'(A_PRIO + n)) rdata_o[7 -: P] = prio_q[n];
        end
    end

    assign en_o     = en_q;
    assign pend_o   = pend_q;
    assign prio_o   = prio_q;
    assign grp_o    = grp_q;
    assign thresh_o = thresh_q;
    assign master_o = master_q;

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int unsigned N = 41,
    parameter int unsigned P = 3
) (
    input  logic [N-1:0]        elig_i,
    input  logic [N-1:0][P-1:0] prio_i,
    output win_t                win_o
);

    // Strict less-than keeps the lowest index on equal levels
    always_comb begin
        win_o = '0;
        for (int i = 0; i < N; i++) begin
            if (elig_i[i] && (!win_o.valid || 8'(prio_i[i]) < win_o.lvl)) begin
                win_o.valid = 1'b1;
                win_o.id    = 8'(i);
                win_o.lvl   = 8'(prio_i[i]);
            end
        end
    end

endmodule

// File: rtl/pic_nest.sv
module pic_nest #(
    parameter int unsigned P     = 3,
    parameter int unsigned DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push_i,
    input  logic [P-1:0]                 lvl_i,
    input  logic                         pop_i,
    output logic                         active_o,
    output logic [P-1:0]                 top_o,
    output logic [$clog2(DEPTH+1)-1:0]   depth_o
);

    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned IW = $clog2(DEPTH);

    logic [P-1:0]  mem [DEPTH];
    logic [CW-1:0] depth_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
        end else if (push_i && pop_i && depth_q != '0) begin
            mem[IW'(depth_q - 1'b1)] <= lvl_i;
        end else if (push_i && depth_q != CW'(DEPTH)) begin
            mem[IW'(depth_q)] <= lvl_i;
            depth_q <= depth_q + 1'b1;
        end else if (pop_i && depth_q != '0) begin
            depth_q <= depth_q - 1'b1;
        end
    end

    assign active_o = (depth_q != '0);
    assign top_o    = (depth_q != '0) ? mem[IW'(depth_q - 1'b1)] : '0;
    assign depth_o  = depth_q;

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int unsigned N_LINES   = 41,
    parameter int unsigned PRIO_BITS = 3,
    parameter int unsigned ID_W      = $clog2(N_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_LINES-1:0]   irq_lines_i,
    input  logic                 reg_we_i,
    input  logic [7:0]           reg_addr_i,
    input  logic [31:0]          reg_wdata_i,
    output logic [31:0]          reg_rdata_o,
    input  logic                 ack_i,
    input  logic                 eos_i,
    output logic                 irq_o,
    output logic [ID_W-1:0]      irq_id_o
);

    localparam int unsigned NEST_DEPTH = 2 ** PRIO_BITS;
    localparam int unsigned DCW        = $clog2(NEST_DEPTH + 1);

    logic [N_LINES-1:0]                en, pend, elig;
    logic [N_LINES-1:0][PRIO_BITS-1:0] prio;
    logic [2:0]                        grp;
    logic [PRIO_BITS-1:0]              thresh, top_lvl;
    logic                              master, active, preempt_ok, claim;
    logic [DCW-1:0]                    depth;
    win_t                              win;
    int unsigned                       gbits;

    pic_regs #(.N(N_LINES), .P(PRIO_BITS)) u_regs (
        .clk(clk), .rst(rst), .lines_i(irq_lines_i),
        .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
        .rdata_o(reg_rdata_o), .ack_clr_i(claim), .ack_id_i(win.id),
        .en_o(en), .pend_o(pend), .prio_o(prio), .grp_o(grp),
        .thresh_o(thresh), .master_o(master)
    );

    // Threshold filter ahead of arbitration
    for (genvar i = 0; i < N_LINES; i++) begin : g_elig
        assign elig[i] = en[i] & pend[i] & ((thresh == '0) || (prio[i] < thresh));
    end

    pic_arbiter #(.N(N_LINES), .P(PRIO_BITS)) u_arb (
        .elig_i(elig), .prio_i(prio), .win_o(win)
    );

    pic_nest #(.P(PRIO_BITS), .DEPTH(NEST_DEPTH)) u_nest (
        .clk(clk), .rst(rst), .push_i(claim), .lvl_i(win.lvl[PRIO_BITS-1:0]),
        .pop_i(eos_i), .active_o(active), .top_o(top_lvl), .depth_o(depth)
    );

    always_comb begin
        gbits      = preempt_bits(grp, PRIO_BITS);
        preempt_ok = !active ||
                     (group_key(win.lvl, gbits, PRIO_BITS) <
                      group_key(8'(top_lvl), gbits, PRIO_BITS));
    end

    assign irq_o    = master && win.valid && preempt_ok;
    assign irq_id_o = win.id[ID_W-1:0];
    assign claim    = ack_i && irq_o;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int unsigned N_LINES   = 41,
    parameter int unsigned PRIO_BITS = 3,
    parameter int unsigned ID_W      = 6,
    parameter int unsigned DCW       = 4
) (
    input logic                                clk,
    input logic                                rst,
    input logic                                irq_o,
    input logic [ID_W-1:0]                     irq_id_o,
    input logic [N_LINES-1:0]                  en,
    input logic [N_LINES-1:0]                  pend,
    input logic [N_LINES-1:0][PRIO_BITS-1:0]   prio,
    input logic [PRIO_BITS-1:0]                thresh,
    input logic [PRIO_BITS-1:0]                top_lvl,
    input logic                                master,
    input logic [DCW-1:0]                      depth,
    input logic                                ack_i,
    input logic                                eos_i
);

    localparam int unsigned NEST_DEPTH = 2 ** PRIO_BITS;

    p_gate_r7: assert property (@(posedge clk) disable iff (rst)
        !master |-> !irq_o);

    p_winner_live_r5: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (en[irq_id_o] && pend[irq_id_o]));

    p_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_o && thresh != '0) |-> (prio[irq_id_o] < thresh));

    p_preempt_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_o && depth != '0) |-> (prio[irq_id_o] < top_lvl));

    p_stack_bound_r9: assert property (@(posedge clk) disable iff (rst)
        depth <= DCW'(NEST_DEPTH));

    p_push_r9: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_o && !eos_i && depth != DCW'(NEST_DEPTH))
        |=> depth == $past(depth) + 1'b1);

    p_pop_r9: assert property (@(posedge clk) disable iff (rst)
        (eos_i && !ack_i && depth != '0) |=> depth == $past(depth) - 1'b1);

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
    .N_LINES(N_LINES), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W), .DCW(DCW)
) u_chk (
    .clk(clk), .rst(rst), .irq_o(irq_o), .irq_id_o(irq_id_o),
    .en(en), .pend(pend), .prio(prio), .thresh(thresh), .top_lvl(top_lvl),
    .master(master), .depth(depth), .ack_i(ack_i), .eos_i(eos_i)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;

    localparam int N    = 41;
    localparam int ID_W = 6;

    localparam logic [7:0] R_CTRL = 8'h00, R_THR = 8'h01, R_ENS = 8'h08, R_ENC = 8'h0C,
                           R_PDS = 8'h10, R_PDC = 8'h14, R_PRI = 8'h40;

    // {line a, line b, level a, level b, threshold, expect irq, expect id}
    localparam logic [31:0] TAB [0:6] = '{
        {8'd3,  8'd7,  3'd5, 3'd2, 3'd0, 1'b1, 6'd7},
        {8'd3,  8'd7,  3'd2, 3'd2, 3'd0, 1'b1, 6'd3},
        {8'd40, 8'd0,  3'd1, 3'd6, 3'd0, 1'b1, 6'd40},
        {8'd3,  8'd7,  3'd4, 3'd5, 3'd4, 1'b0, 6'd0},
        {8'd3,  8'd7,  3'd4, 3'd3, 3'd4, 1'b1, 6'd7},
        {8'd10, 8'd20, 3'd0, 3'd0, 3'd1, 1'b1, 6'd10},
        {8'd12, 8'd5,  3'd6, 3'd7, 3'd7, 1'b1, 6'd12}
    };

    logic            clk = 1'b0, rst = 1'b1;
    logic [N-1:0]    lines = '0;
    logic            we = 1'b0, ack = 1'b0, eos = 1'b0;
    logic [7:0]      addr = '0;
    logic [31:0]     wdata = '0, rdata;
    logic            irq;
    logic [ID_W-1:0] irq_id;
    int              n_cmp = 0, n_bad = 0;
    bit              done = 0;

    always #10 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst(rst), .irq_lines_i(lines), .reg_we_i(we),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .ack_i(ack), .eos_i(eos), .irq_o(irq), .irq_id_o(irq_id)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic pulse_eos();
        @(negedge clk); eos = 1'b1;
        @(negedge clk); eos = 1'b0;
    endtask

    task automatic set_bit(input logic [7:0] base, input int ln);
        wr(8'(base + ln / 32), 32'd1 << (ln % 32));
    endtask

    task automatic set_lvl(input int ln, input logic [2:0] lvl);
        wr(8'(R_PRI + ln), {24'd0, lvl, 5'd0});
    endtask

    task automatic clear_all();
        for (int w = 0; w < 2; w++) begin
            wr(8'(R_ENC + w), 32'hFFFF_FFFF);
            wr(8'(R_PDC + w), 32'hFFFF_FFFF);
        end
    endtask

    task automatic chk_irq(input logic ei, input int eid, input string tag);
        #1;
        n_cmp++;
        if (irq !== ei || (ei && irq_id !== ID_W'(eid))) begin
            n_bad++;
            $display("FAIL %s: irq=%0b id=%0d expected irq=%0b id=%0d", tag, irq, irq_id, ei, eid);
        end
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #1;
        n_cmp++;
        if (rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: addr=%h read=%h expected=%h", tag, a, rdata, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk_irq(1'b0, 0, "R1 irq after reset");
        rd_chk(R_CTRL, 32'h0, "R1 control");
        rd_chk(R_THR, 32'h0, "R1 threshold");
        rd_chk(R_ENS, 32'h0, "R1 enables");
        rd_chk(R_PDS + 8'd1, 32'h0, "R1 pending upper");
        rd_chk(8'(R_PRI + 40), 32'h0, "R1 level");

        wr(R_CTRL, 32'h1);
        // R5 R6 vector table
        for (int k = 0; k < 7; k++) begin
            clear_all();
            wr(R_THR, {24'd0, TAB[k][9:7], 5'd0});
            set_lvl(int'(TAB[k][31:24]), TAB[k][15:13]);
            set_lvl(int'(TAB[k][23:16]), TAB[k][12:10]);
            set_bit(R_ENS, int'(TAB[k][31:24]));
            set_bit(R_ENS, int'(TAB[k][23:16]));
            set_bit(R_PDS, int'(TAB[k][31:24]));
            set_bit(R_PDS, int'(TAB[k][23:16]));
            chk_irq(TAB[k][6], int'(TAB[k][5:0]), $sformatf("R5/R6 vector %0d", k));
        end
        clear_all();
        wr(R_THR, 32'h0);

        // R7 master gate
        set_lvl(5, 3'd2); set_bit(R_ENS, 5); set_bit(R_PDS, 5);
        wr(R_CTRL, 32'h0);
        chk_irq(1'b0, 0, "R7 gate closed");
        rd_chk(R_ENS, 32'h20, "R7 enable kept");
        wr(R_CTRL, 32'h1);
        chk_irq(1'b1, 5, "R7 gate open");

        // R3 pending clear discards; disabled pending never wins
        set_bit(R_PDC, 5);
        chk_irq(1'b0, 0, "R3 discard");
        rd_chk(R_PDS, 32'h0, "R3 pending cleared");
        set_bit(R_PDS, 6);
        chk_irq(1'b0, 0, "R3 disabled pending");
        rd_chk(R_PDC, 32'h40, "R3 pending readback");
        set_bit(R_PDC, 6);

        // R2 enable clear
        set_bit(R_ENC, 5);
        rd_chk(R_ENC, 32'h0, "R2 enable cleared");
        set_bit(R_PDS, 5);
        chk_irq(1'b0, 0, "R2 disabled line silent");
        set_bit(R_PDC, 5);

        // R4 unimplemented bits
        wr(8'(R_PRI + 3), 32'hFF);
        rd_chk(8'(R_PRI + 3), 32'hE0, "R4 level low bits");
        wr(R_CTRL, 32'hFFFF_FFFF);
        rd_chk(R_CTRL, 32'h701, "R4 control bits");
        wr(R_CTRL, 32'h1);

        // R10 asserted line re-pends
        set_lvl(9, 3'd1); set_bit(R_ENS, 9);
        @(negedge clk); lines[9] = 1'b1;
        @(negedge clk);
        chk_irq(1'b1, 9, "R10 line pends");
        set_bit(R_PDC, 9);
        rd_chk(R_PDS, 32'h200, "R10 clear while asserted");
        @(negedge clk); lines[9] = 1'b0;
        set_bit(R_PDC, 9);
        rd_chk(R_PDS, 32'h0, "R10 clear after release");
        chk_irq(1'b0, 0, "R10 idle");

        // R8 R9 nesting, grouping 0
        clear_all();
        set_lvl(5, 3'd3); set_lvl(8, 3'd3); set_lvl(2, 3'd1);
        set_bit(R_ENS, 5); set_bit(R_ENS, 8); set_bit(R_ENS, 2);
        set_bit(R_PDS, 5);
        chk_irq(1'b1, 5, "R9 first request");
        pulse_ack();
        rd_chk(R_PDS, 32'h0, "R9 ack clears pending");
        chk_irq(1'b0, 0, "R9 in service");
        set_bit(R_PDS, 8);
        chk_irq(1'b0, 0, "R8 equal group waits");
        set_bit(R_PDS, 2);
        chk_irq(1'b1, 2, "R8 urgent preempts");
        pulse_ack();
        chk_irq(1'b0, 0, "R9 nested");
        pulse_eos();
        chk_irq(1'b0, 0, "R9 back to outer");
        pulse_eos();
        chk_irq(1'b1, 8, "R9 waiting request released");
        pulse_ack();
        pulse_eos();
        chk_irq(1'b0, 0, "R9 drained");

        // R8 sub-priority never preempts (grouping 6: one group bit)
        clear_all();
        wr(R_CTRL, 32'h601);
        set_lvl(4, 3'd1); set_lvl(11, 3'd0); set_lvl(12, 3'd4);
        set_bit(R_ENS, 4); set_bit(R_ENS, 11); set_bit(R_ENS, 12);
        set_bit(R_PDS, 4);
        chk_irq(1'b1, 4, "R8 grouping6 first");
        pulse_ack();
        set_bit(R_PDS, 11); set_bit(R_PDS, 12);
        chk_irq(1'b0, 0, "R8 sub-priority no preempt");
        pulse_eos();
        chk_irq(1'b1, 11, "R8 after pop");
        pulse_ack(); pulse_eos();
        chk_irq(1'b1, 12, "R8 next in line");
        pulse_ack(); pulse_eos();

        // R8 boundary: encoding 4 keeps three group bits, 5 keeps two
        clear_all();
        wr(R_CTRL, 32'h401);
        set_lvl(20, 3'd3); set_lvl(21, 3'd2);
        set_bit(R_ENS, 20); set_bit(R_ENS, 21);
        set_bit(R_PDS, 20);
        chk_irq(1'b1, 20, "R8 grouping4 first");
        pulse_ack();
        set_bit(R_PDS, 21);
        chk_irq(1'b1, 21, "R8 grouping4 preempts");
        pulse_ack(); pulse_eos(); pulse_eos();
        wr(R_CTRL, 32'h501);
        set_bit(R_PDS, 20);
        pulse_ack();
        set_bit(R_PDS, 21);
        chk_irq(1'b0, 0, "R8 grouping5 same group");
        pulse_eos();
        chk_irq(1'b1, 21, "R8 grouping5 after pop");
        pulse_ack(); pulse_eos();
        chk_irq(1'b0, 0, "R9 final idle");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule